// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block is the control unit of a small 8-bit processor. It keeps the current instruction byte in an instruction register and counts micro-steps with a 4-bit step counter. Each cycle a microcode lookup turns the upper four instruction bits and the step count into a 16-bit control word for the datapath. The word carries register and memory write strobes, bus drive selects, a two-bit ALU function, program-counter increment and load, and two sequencing bits: one that latches a halt and one that sends the step counter back to zero.

The lookup is split into two 8-bit halves, one for the low byte and one for the high byte of the word. Steps 0 and 1 of every instruction form a common fetch. Later steps depend on the opcode. An instruction ends early by raising the step-return bit. An opcode with no microcode runs through all sixteen steps with a zero word and then wraps.

A halt latch freezes everything once it is set: the step counter and instruction register hold, and the control word is forced to zero, so no write strobe and no program-counter change can reach the datapath. The external `halt_clr` input releases the latch, and execution resumes at step 0.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `step_o` is 0, `ir_o` is 0 and `halted_o` is 0.
- R2: Control word bit meanings are: 0 PC to address bus, 1 instruction register load, 2 PC increment, 3 PC load, 4 address register load, 5 memory drive, 6 memory write, 7 register A load, 8 register B load, 9 register A drive, 10 register B drive, 11 ALU drive, 12-13 ALU function, 14 halt set, 15 step return. When not halted, step 0 gives 16'h0011 and step 1 gives 16'h0026 for every opcode.
- R3: When not halted and the step-return bit is low, `step_o` rises by one at each clock edge, and wraps from 15 to 0.
- R4: When not halted and the step-return bit is high, `step_o` is 0 after the next edge.
- R5: `ir_o` takes the value of `bus_in` at an edge where bit 1 of `ctrl_o` is high, and holds otherwise. The opcode is `ir_o[7:4]`.
- R6: For steps 2 and later, the words are: op 0 {8000}; op 1 {0011, 80A4}; op 2 {8880}; op 3 {9880}; op 4 {A880}; op 5 {B880}; op 6 {0011, 0034, 8240}; op 7 {0011, 8028}; op 8 {8300}; op 15 {C000} (all hex, listed from step 2 onward).
- R7: Opcodes 9 to 14 give an all-zero word in steps 2 to 15.
- R8: A high halt-set bit with `halt_clr` low sets `halted_o` after the edge. While halted, `ctrl_o` is all zero and `step_o` and `ir_o` hold, whatever `bus_in` carries.
- R9: `halt_clr` high makes `halted_o` low after the edge. It takes priority over a simultaneous halt-set bit. After release, execution restarts at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Data bus value offered to the instruction register |
| halt_clr | input | 1 | External release of the halt latch |
| ctrl_o | output | 16 | Control word for the datapath |
| step_o | output | 4 | Current micro-step |
| ir_o | output | 8 | Instruction register contents |
| halted_o | output | 1 | Halt latch state |

## Verification
Several properties are checked on every cycle: the step counter either advances by one or returns to zero, step and instruction register stay put during a halt, a halt outputs a zero word, the halt set and release timing holds, the instruction register captures the bus whenever its load bit is high, and the fetch word appears at step 0. The exact microcode contents for each opcode can only be shown by the bench's scenarios. The same is true of the sixteen-step wrap of undefined opcodes, of release winning a tie with halt-set, and of a halted unit ignoring bus traffic. The bench runs an instruction sequence and compares every cycle against a word table it holds itself.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int CW_W   = 16;
  localparam int STEP_W = 4;
  localparam int OP_W   = 4;
  localparam int HALF_W = CW_W / 2;

  typedef logic [CW_W-1:0]   cword_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [OP_W-1:0]   op_t;

  // control word bit positions
  localparam int CB_PC_ADDR  = 0;
  localparam int CB_IR_LD    = 1;
  localparam int CB_PC_INC   = 2;
  localparam int CB_PC_LD    = 3;
  localparam int CB_MAR_LD   = 4;
  localparam int CB_MEM_DRV  = 5;
  localparam int CB_MEM_WR   = 6;
  localparam int CB_RA_LD    = 7;
  localparam int CB_RB_LD    = 8;
  localparam int CB_RA_DRV   = 9;
  localparam int CB_RB_DRV   = 10;
  localparam int CB_ALU_DRV  = 11;
  localparam int CB_ALU_F0   = 12;
  localparam int CB_ALU_F1   = 13;
  localparam int CB_HALT_SET = 14;
  localparam int CB_STEP_RET = 15;

  typedef enum logic [OP_W-1:0] {
    OPC_NOP = 4'h0, OPC_LDI = 4'h1, OPC_ADD = 4'h2, OPC_SUB = 4'h3,
    OPC_AND = 4'h4, OPC_XOR = 4'h5, OPC_STA = 4'h6, OPC_JMP = 4'h7,
    OPC_MOV = 4'h8, OPC_HLT = 4'hF
  } opc_e;

  function automatic cword_t bit_of(input int pos);
    cword_t w;
    w = '0;
    w[pos] = 1'b1;
    return w;
  endfunction

  // step incrementer: wraps at the top of the counter range
  function automatic step_t step_inc(input step_t s);
    return s + step_t'(1);
  endfunction

  function automatic cword_t alu_word(input logic [1:0] fn);
    cword_t w;
    w = bit_of(CB_ALU_DRV) | bit_of(CB_RA_LD) | bit_of(CB_STEP_RET);
    w[CB_ALU_F0] = fn[0];
    w[CB_ALU_F1] = fn[1];
    return w;
  endfunction

  // microcode: fetch in steps 0/1, then opcode-specific steps
  function automatic cword_t ucode_word(input op_t op, input step_t st);
    cword_t fetch_a, fetch_b, w;
    fetch_a = bit_of(CB_PC_ADDR) | bit_of(CB_MAR_LD);
    fetch_b = bit_of(CB_MEM_DRV) | bit_of(CB_IR_LD) | bit_of(CB_PC_INC);
    w = '0;
    if (st == step_t'(0)) begin
      w = fetch_a;
    end else if (st == step_t'(1)) begin
      w = fetch_b;
    end else begin
      case ({op, st})
        {OPC_NOP, 4'd2}: w = bit_of(CB_STEP_RET);
        {OPC_LDI, 4'd2}: w = fetch_a;
        {OPC_LDI, 4'd3}: w = bit_of(CB_MEM_DRV) | bit_of(CB_RA_LD)
                             | bit_of(CB_PC_INC) | bit_of(CB_STEP_RET);
        {OPC_ADD, 4'd2}: w = alu_word(2'd0);
        {OPC_SUB, 4'd2}: w = alu_word(2'd1);
        {OPC_AND, 4'd2}: w = alu_word(2'd2);
        {OPC_XOR, 4'd2}: w = alu_word(2'd3);
        {OPC_STA, 4'd2}: w = fetch_a;
        {OPC_STA, 4'd3}: w = bit_of(CB_MEM_DRV) | bit_of(CB_MAR_LD)
                             | bit_of(CB_PC_INC);
        {OPC_STA, 4'd4}: w = bit_of(CB_RA_DRV) | bit_of(CB_MEM_WR)
                             | bit_of(CB_STEP_RET);
        {OPC_JMP, 4'd2}: w = fetch_a;
        {OPC_JMP, 4'd3}: w = bit_of(CB_MEM_DRV) | bit_of(CB_PC_LD)
                             | bit_of(CB_STEP_RET);
        {OPC_MOV, 4'd2}: w = bit_of(CB_RA_DRV) | bit_of(CB_RB_LD)
                             | bit_of(CB_STEP_RET);
        {OPC_HLT, 4'd2}: w = bit_of(CB_HALT_SET) | bit_of(CB_STEP_RET);
        default:         w = '0;
      endcase
    end
    return w;
  endfunction

  // one 8-bit lookup half of the microcode
  function automatic logic [HALF_W-1:0] ucode_half(input op_t op, input step_t st,
                                                  input int half);
    cword_t w;
    w = ucode_word(op, st);
    return w[half*HALF_W +: HALF_W];
  endfunction

endpackage

// File: rtl/useq_step.sv
module useq_step
  import useq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  ret,
  output step_t step_o
);

  step_t step_q;
  step_t step_d;

  always_comb begin
    if (hold)     step_d = step_q;
    else if (ret) step_d = '0;
    else          step_d = step_inc(step_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step_o = step_q;

  // R3: plain advance by one when free to run
  a_r3_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !ret) |=> (step_q == step_t'($past(step_q) + 1'b1)));

  // R4: return bit sends the counter home
  a_r4_step_return: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && ret) |=> (step_q == '0));

  // R8: frozen while halted
  a_r8_step_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(step_q));

endmodule

// File: rtl/useq_rom_half.sv
module useq_rom_half
  import useq_pkg::*;
#(
  parameter int HALF = 0
) (
  input  op_t               op,
  input  step_t             step,
  output logic [HALF_W-1:0] byte_o
);

  always_comb byte_o = ucode_half(op, step, HALF);

endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  op_t    op,
  input  step_t  step,
  output cword_t word_o
);

  localparam int N_HALVES = CW_W / HALF_W;

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    useq_rom_half #(.HALF(h)) i_half (
      .op    (op),
      .step  (step),
      .byte_o(word_o[h*HALF_W +: HALF_W])
    );
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int IR_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IR_W-1:0] bus_in,
  input  logic            halt_clr,
  output logic [15:0]     ctrl_o,
  output logic [3:0]      step_o,
  output logic [IR_W-1:0] ir_o,
  output logic            halted_o
);

  localparam int OP_LSB = IR_W - OP_W;

  logic [IR_W-1:0] ir_q;
  logic            halted_q;
  step_t           step_w;
  cword_t          raw_word;
  op_t             op_w;

  // named internal events
  logic ir_load_ev;
  logic halt_set_ev;
  logic step_ret_ev;

  assign op_w = ir_q[IR_W-1:OP_LSB];

  useq_decode i_decode (
    .op    (op_w),
    .step  (step_w),
    .word_o(raw_word)
  );

  // halt gates the whole word: no strobe escapes while frozen
  assign ctrl_o      = halted_q ? '0 : raw_word;
  assign ir_load_ev  = ctrl_o[CB_IR_LD];
  assign halt_set_ev = ctrl_o[CB_HALT_SET];
  assign step_ret_ev = ctrl_o[CB_STEP_RET];

  useq_step i_step (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (halted_q),
    .ret   (step_ret_ev),
    .step_o(step_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ir_q <= '0;
    else if (ir_load_ev) ir_q <= bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           halted_q <= 1'b0;
    else if (halt_clr)    halted_q <= 1'b0;
    else if (halt_set_ev) halted_q <= 1'b1;
  end

  assign step_o   = step_w;
  assign ir_o     = ir_q;
  assign halted_o = halted_q;

  // R5: capture on load strobe
  a_r5_ir_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load_ev |=> (ir_q == $past(bus_in)));

  // R8: halt latch sets from the word
  a_r8_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_set_ev && !halt_clr) |=> halted_q);

  // R8: frozen instruction register and silent word while halted
  a_r8_ir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> $stable(ir_q));

  a_r8_quiet_word: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> (ctrl_o == '0));

  // R9: external release wins
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    halt_clr |=> !halted_q);

  // R2: fetch word opens every instruction
  a_r2_fetch_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted_q && step_w == '0) |-> (ctrl_o == 16'h0011));

endmodule

// File: tb/test_useq_ctrl.sv
`timescale 1ns/1ps
module test_useq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_in = 8'h00;
  logic        halt_clr = 1'b0;
  logic [15:0] ctrl_o;
  logic [3:0]  step_o;
  logic [7:0]  ir_o;
  logic        halted_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [15:0] q_cw[$];
  logic [3:0]  q_st[$];
  logic [7:0]  q_ir[$];
  logic        q_hl[$];
  string       q_tag[$];
  string       q_stag[$];

  logic [7:0] cur_ir = 8'h00;
  string      s0_tag = "R1";

  always #2 clk = ~clk;

  useq_ctrl i_useq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .halt_clr(halt_clr),
    .ctrl_o(ctrl_o), .step_o(step_o), .ir_o(ir_o), .halted_o(halted_o)
  );

  // expected words, restated from R2/R6/R7
  function automatic logic [15:0] exp_word(input logic [3:0] op, input int s);
    if (s == 0) return 16'h0011;
    if (s == 1) return 16'h0026;
    case (op)
      4'h0: return (s == 2) ? 16'h8000 : 16'h0000;
      4'h1: return (s == 2) ? 16'h0011 : (s == 3) ? 16'h80A4 : 16'h0000;
      4'h2: return (s == 2) ? 16'h8880 : 16'h0000;
      4'h3: return (s == 2) ? 16'h9880 : 16'h0000;
      4'h4: return (s == 2) ? 16'hA880 : 16'h0000;
      4'h5: return (s == 2) ? 16'hB880 : 16'h0000;
      4'h6: return (s == 2) ? 16'h0011 : (s == 3) ? 16'h0034
                 : (s == 4) ? 16'h8240 : 16'h0000;
      4'h7: return (s == 2) ? 16'h0011 : (s == 3) ? 16'h8028 : 16'h0000;
      4'h8: return (s == 2) ? 16'h8300 : 16'h0000;
      4'hF: return (s == 2) ? 16'hC000 : 16'h0000;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic push(input logic [15:0] w, input logic [3:0] st, input logic [7:0] irv,
                      input logic hl, input string tag, input string stag);
    q_cw.push_back(w); q_st.push_back(st); q_ir.push_back(irv);
    q_hl.push_back(hl); q_tag.push_back(tag); q_stag.push_back(stag);
  endtask

  // driver: one instruction, cycle by cycle
  task automatic exec(input logic [7:0] b, input bit clr_last);
    logic [3:0]  op;
    logic [15:0] w;
    bit          last;
    string       tag;
    op = b[7:4];
    w = 16'h0;
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      w = exp_word(op, s);
      last = w[15] || (s == 15);
      bus_in = (s == 1) ? b : ~b;
      halt_clr = last && clr_last;
      if (s < 2)                      tag = "R2";
      else if (op >= 4'h9 && op <= 4'hE) tag = "R7";
      else                            tag = "R6";
      push(w, 4'(s), (s < 2) ? cur_ir : b, 1'b0, tag, (s == 0) ? s0_tag : "R3");
      if (last) break;
    end
    cur_ir = b;
    s0_tag = w[15] ? "R4" : "R3";
  endtask

  task automatic stay_halted(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      halt_clr = 1'b0;
      bus_in = 8'hC3 ^ 8'(k);
      push(16'h0, 4'h0, cur_ir, 1'b1, "R8", "R8");
    end
  endtask

  task automatic release_halt();
    @(negedge clk);
    halt_clr = 1'b1;
    bus_in = 8'h77;
    push(16'h0, 4'h0, cur_ir, 1'b1, "R9", "R8");
    s0_tag = "R9";
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops and compares once per cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_cw.size() > 0) begin
        logic [15:0] w; logic [3:0] st; logic [7:0] irv; logic hl; string tag; string stag;
        w = q_cw.pop_front(); st = q_st.pop_front(); irv = q_ir.pop_front();
        hl = q_hl.pop_front(); tag = q_tag.pop_front(); stag = q_stag.pop_front();
        chk(tag, "ctrl", int'(ctrl_o), int'(w));
        chk(stag, "step", int'(step_o), int'(st));
        chk(hl ? tag : "R5", "ir", int'(ir_o), int'(irv));
        chk(hl ? tag : "R8", "halted", int'(halted_o), int'(hl));
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bus_in = 8'hA5;
    repeat (2) @(negedge clk);
    // R1: state during reset
    chk("R1", "step", int'(step_o), 0);
    chk("R1", "ir", int'(ir_o), 0);
    chk("R1", "halted", int'(halted_o), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    exec(8'h00, 1'b0);   // NOP
    exec(8'h1A, 1'b0);   // load immediate
    exec(8'h21, 1'b0);   // ALU group
    exec(8'h32, 1'b0);
    exec(8'h43, 1'b0);
    exec(8'h54, 1'b0);
    exec(8'h65, 1'b0);   // store
    exec(8'h76, 1'b0);   // jump
    exec(8'h87, 1'b0);   // move
    exec(8'h9B, 1'b0);   // undefined: sixteen steps then wrap
    exec(8'hE1, 1'b0);
    exec(8'hF0, 1'b1);   // halt with simultaneous release: keeps running
    exec(8'h2C, 1'b0);
    exec(8'hF3, 1'b0);   // real halt
    stay_halted(6);
    release_halt();
    exec(8'h55, 1'b0);
    exec(8'h00, 1'b0);

    @(negedge clk);
    halt_clr = 1'b0;
    wait (q_cw.size() == 0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule